// File: doc/BRIEF.md
# Dual Countdown Timer with Interrupt Aggregation

This block holds two independent down-counters behind a 32-bit word register interface. For each counter, software sets a limit value and a control word. The control word picks one of four tick-enable inputs as the count rate, and chooses between auto-reload and single-shot operation. Writing the control word loads the counter from its limit, and counting then starts on the selected ticks. Software can read back the live count at any time.

When a counter expires, it sets its own bit in a raw interrupt register. Software enables bits through a mask register and clears raw bits by writing ones to an acknowledge register. It can read the masked bits from a status register. The single level interrupt output is high while any masked bit is set. The tick rates are modelled as single-cycle enable strobes, so every register in the block runs on one system clock.

The register port is a request channel that uses valid/ready. `bus_ready` is tied high, so the block never applies back-pressure, and a request is accepted in every cycle in which `bus_valid` is high. A read is answered one cycle after it is accepted: `rsp_valid` is high for one cycle together with `rsp_rdata`. The response channel has no ready, so the requester must always be able to take the response.

Top module: `dual_tick_timer`

## Requirements
- R1: Registers sit at these byte offsets: timer 0 limit 0x00, count 0x04, control 0x08; timer 1 limit 0x10, count 0x14, control 0x18; mask 0x48, acknowledge 0x4C (write-only, reads 0), masked status 0x54. An access whose address has nonzero bits [1:0], or an address of 0x5C or above, writes nothing and reads 0.
- R2: A control write loads the count from that timer's limit register. A write to the limit register alone leaves the count unchanged. A count read returns the live count.
- R3: Control bits [2:0] are the source code. Codes 4, 5, 6 and 7 select tick_en[0], [1], [2] and [3]. With a code below 4, the timer never counts. The control register reads back as bits [3:0].
- R4: Each selected tick lowers a running count above 1 by one. With no selected tick, the count holds.
- R5: With control bit 3 = 1 (auto-reload), a selected tick at a count of 1 or 0 is an expiry, and the count reloads from the limit.
- R6: With control bit 3 = 0 (single-shot), an expiry leaves the count at 0 and stops the timer. Later ticks have no effect until the next control write.
- R7: Timer 0 expiry sets raw bit 0. Timer 1 expiry sets raw bit 1.
- R8: Writing the acknowledge register clears each raw bit whose written bit is 1. An expiry in the same cycle wins, and its bit stays set.
- R9: Masked status (bits [1:0]) equals raw AND mask (mask bits [1:0]). `irq` is high exactly when the masked status is nonzero.
- R10: Reset clears the counts, limits, controls, mask and raw bits, stops both timers and holds `irq` low.
- R11: `bus_ready` is always high. `rsp_valid` pulses one cycle after each accepted read, and only then, with the data in `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 4 | Tick-enable strobes for source codes 4..7 |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Register request ready (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check, on every cycle, the count step rules: a control write loads the limit, the count holds without a tick, it decrements on a tick, it reloads in auto-reload, and it parks at 0 in single-shot. They also check that an expiry sets its raw bit even against an acknowledge, that an acknowledge clears the written bits, that raw bits hold when nothing touches them, and that every accepted read gets a response and nothing else does. Only the bench's scenarios can show the items that depend on the address map and the software view. These are the decode of each offset, the rejection of misaligned and out-of-window accesses, the mapping of source codes to strobes, the mask, the masked status, the interrupt level, and the cleared state after a reset in the middle of operation.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  // control word as stored per timer
  typedef struct packed {
    logic       reload;   // 1 = auto-reload, 0 = single-shot
    logic [2:0] sel;      // source code
  } tmr_ctrl_t;

  localparam int CTRL_W     = 4;
  localparam int SEL_W      = 3;
  localparam int FIRST_CODE = 4;   // lowest code that maps to a strobe

  // offsets inside one timer slot (slot = 16 bytes)
  localparam logic [3:0] SLOT_LIMIT = 4'h0;
  localparam logic [3:0] SLOT_COUNT = 4'h4;
  localparam logic [3:0] SLOT_CTRL  = 4'h8;

  // shared interrupt registers
  localparam logic [6:0] A_MASK  = 7'h48;
  localparam logic [6:0] A_ACK   = 7'h4C;
  localparam logic [6:0] A_MSTAT = 7'h54;
  localparam logic [6:0] A_END   = 7'h5C;
endpackage

// File: rtl/tick_sel.sv
module tick_sel import dtt_pkg::*; #(
  parameter int N_SRC = 4
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [N_SRC-1:0] src_en,
  output logic             tick
);
  // codes below FIRST_CODE select nothing: no tick at all
  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel == SEL_W'(FIRST_CODE + i)) tick = src_en[i];
    end
  end
endmodule

// File: rtl/countdown_unit.sv
module countdown_unit import dtt_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             limit_we,
  input  logic             ctrl_we,
  input  logic [CNT_W-1:0] wdata,
  input  tmr_ctrl_t        ctrl_in,
  input  logic             tick,
  output logic [CNT_W-1:0] limit_q,
  output tmr_ctrl_t        ctrl_q,
  output logic [CNT_W-1:0] count_q,
  output logic             expire
);
  logic running;
  logic at_end;

  assign at_end = (count_q <= CNT_W'(1));
  assign expire = running && tick && at_end && !ctrl_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      ctrl_q  <= '0;
      count_q <= '0;
      running <= 1'b0;
    end else begin
      if (limit_we) limit_q <= wdata;
      if (ctrl_we) begin
        ctrl_q  <= ctrl_in;
        count_q <= limit_q;
        running <= 1'b1;
      end else if (running && tick) begin
        if (at_end) begin
          if (ctrl_q.reload) begin
            count_q <= limit_q;
          end else begin
            count_q <= '0;
            running <= 1'b0;
          end
        end else begin
          count_q <= count_q - CNT_W'(1);
        end
      end
    end
  end

  // R2: control write loads the limit
  p_load_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> count_q == $past(limit_q));
  // R4: no tick, no change
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_we && !tick) |=> $stable(count_q));
  // R4: one step down per tick
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_we && tick && running && !at_end) |=> count_q == $past(count_q) - CNT_W'(1));
  // R5: auto-reload on expiry
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_q.reload) |=> count_q == $past(limit_q));
  // R6: single-shot parks
  p_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_q.reload) |=> (count_q == '0 && !running));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int N_TMR = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_TMR-1:0] expire,
  input  logic             mask_we,
  input  logic             ack_we,
  input  logic [N_TMR-1:0] wbits,
  output logic [N_TMR-1:0] mask_q,
  output logic [N_TMR-1:0] raw_q,
  output logic [N_TMR-1:0] masked,
  output logic             irq
);
  logic [N_TMR-1:0] clr;

  assign clr    = ack_we ? wbits : '0;
  assign masked = raw_q & mask_q;
  assign irq    = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      if (mask_we) mask_q <= wbits;
      raw_q <= (raw_q & ~clr) | expire;   // set beats clear
    end
  end

  // R8: expiry always lands, acknowledge or not
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire != '0) |=> ((raw_q & $past(expire)) == $past(expire)));
  // R8: acknowledged bits drop unless re-set
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> ((raw_q & $past(wbits & ~expire)) == '0));
  // R7: raw bits only move on expiry or acknowledge
  p_raw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_we && expire == '0) |=> $stable(raw_q));
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer import dtt_pkg::*; #(
  parameter int CNT_W  = 32,
  parameter int N_SRC  = 4,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  tick_en,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              irq
);
  localparam int N_TMR  = 2;
  localparam int SLOT_W = ADDR_W - 4;

  logic             legal, wr_ok, rd_ok;
  logic [N_TMR-1:0] expire, mask_q, raw_q, masked;
  logic [CNT_W-1:0] limit_a [N_TMR];
  logic [CNT_W-1:0] count_a [N_TMR];
  tmr_ctrl_t        ctrl_a  [N_TMR];
  logic [31:0]      rd_word;

  assign bus_ready = 1'b1;
  assign legal = (bus_addr[1:0] == 2'b00) && (bus_addr < A_END);
  assign wr_ok = bus_valid && bus_write && legal;
  assign rd_ok = bus_valid && !bus_write;

  for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
    logic in_slot, tick;
    assign in_slot = (bus_addr[ADDR_W-1:4] == SLOT_W'(t));

    tick_sel #(.N_SRC(N_SRC)) u_sel (
      .sel    (ctrl_a[t].sel),
      .src_en (tick_en),
      .tick   (tick)
    );

    countdown_unit #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .limit_we (wr_ok && in_slot && bus_addr[3:0] == SLOT_LIMIT),
      .ctrl_we  (wr_ok && in_slot && bus_addr[3:0] == SLOT_CTRL),
      .wdata    (bus_wdata[CNT_W-1:0]),
      .ctrl_in  (tmr_ctrl_t'(bus_wdata[CTRL_W-1:0])),
      .tick     (tick),
      .limit_q  (limit_a[t]),
      .ctrl_q   (ctrl_a[t]),
      .count_q  (count_a[t]),
      .expire   (expire[t])
    );
  end

  irq_ctrl #(.N_TMR(N_TMR)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .mask_we (wr_ok && bus_addr == A_MASK),
    .ack_we  (wr_ok && bus_addr == A_ACK),
    .wbits   (bus_wdata[N_TMR-1:0]),
    .mask_q  (mask_q),
    .raw_q   (raw_q),
    .masked  (masked),
    .irq     (irq)
  );

  always_comb begin
    rd_word = '0;
    if (legal) begin
      for (int t = 0; t < N_TMR; t++) begin
        if (bus_addr[ADDR_W-1:4] == SLOT_W'(t)) begin
          case (bus_addr[3:0])
            SLOT_LIMIT: rd_word = 32'(limit_a[t]);
            SLOT_COUNT: rd_word = 32'(count_a[t]);
            SLOT_CTRL:  rd_word = 32'(ctrl_a[t]);
            default:    rd_word = '0;
          endcase
        end
      end
      if (bus_addr == A_MASK)  rd_word = 32'(mask_q);
      if (bus_addr == A_MSTAT) rd_word = 32'(masked);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_ok;
      rsp_rdata <= rd_ok ? rd_word : '0;
    end
  end

  // R11: every accepted read is answered next cycle
  p_read_answered_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |=> rsp_valid);
  // R11: no response without a read
  p_no_stray_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> !rsp_valid);
  // R9: output high implies an enabled raw bit
  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((raw_q & mask_q) != '0));
endmodule

// File: tb/sim_dual_tick_timer.sv
module sim_dual_tick_timer;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  k;    // 0 idle, 1 write, 2 read
    logic [6:0]  a;
    logic [31:0] d;
    logic [3:0]  t;    // tick strobes
    logic [7:0]  req;  // requirement number for messages
    logic [31:0] e;    // expected read data
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 7'h00, 32'd3,   4'h0, 8'd1,  32'd0}, // R1 limit0=3
    '{2'd1, 7'h48, 32'd3,   4'h0, 8'd9,  32'd0}, // R9 mask both
    '{2'd1, 7'h08, 32'hC,   4'h0, 8'd2,  32'd0}, // R2 code4 reload
    '{2'd2, 7'h04, 32'd0,   4'h0, 8'd2,  32'd3}, // R2 loaded
    '{2'd0, 7'h00, 32'd0,   4'h1, 8'd4,  32'd0}, // R4 tick ->2
    '{2'd0, 7'h00, 32'd0,   4'h2, 8'd3,  32'd0}, // R3 other source
    '{2'd2, 7'h04, 32'd0,   4'h0, 8'd4,  32'd2}, // R4 count 2
    '{2'd0, 7'h00, 32'd0,   4'h1, 8'd4,  32'd0}, // ->1
    '{2'd0, 7'h00, 32'd0,   4'h1, 8'd5,  32'd0}, // R5 expiry
    '{2'd2, 7'h04, 32'd0,   4'h0, 8'd5,  32'd3}, // R5 reloaded
    '{2'd2, 7'h54, 32'd0,   4'h0, 8'd7,  32'd1}, // R7 bit0
    '{2'd1, 7'h4C, 32'd1,   4'h0, 8'd8,  32'd0}, // R8 ack
    '{2'd2, 7'h54, 32'd0,   4'h0, 8'd8,  32'd0}, // R8 cleared
    '{2'd1, 7'h10, 32'd2,   4'h0, 8'd1,  32'd0}, // limit1=2
    '{2'd1, 7'h18, 32'h7,   4'h0, 8'd6,  32'd0}, // R6 code7 single
    '{2'd2, 7'h14, 32'd0,   4'h0, 8'd2,  32'd2}, // R2 timer1 loaded
    '{2'd0, 7'h00, 32'd0,   4'h8, 8'd4,  32'd0}, // ->1
    '{2'd0, 7'h00, 32'd0,   4'h8, 8'd6,  32'd0}, // expiry
    '{2'd2, 7'h14, 32'd0,   4'h0, 8'd6,  32'd0}, // R6 parked
    '{2'd0, 7'h00, 32'd0,   4'h8, 8'd6,  32'd0}, // ignored tick
    '{2'd2, 7'h14, 32'd0,   4'h0, 8'd6,  32'd0}, // R6 still 0
    '{2'd2, 7'h54, 32'd0,   4'h0, 8'd7,  32'd2}, // R7 bit1
    '{2'd2, 7'h04, 32'd0,   4'h0, 8'd3,  32'd3}, // R3 timer0 untouched
    '{2'd1, 7'h48, 32'd1,   4'h0, 8'd9,  32'd0}, // mask bit0 only
    '{2'd2, 7'h54, 32'd0,   4'h0, 8'd9,  32'd0}, // R9 masked off
    '{2'd2, 7'h48, 32'd0,   4'h0, 8'd1,  32'd1}, // R1 mask read
    '{2'd1, 7'h4C, 32'd2,   4'h0, 8'd8,  32'd0}, // ack bit1
    '{2'd1, 7'h08, 32'h3,   4'h0, 8'd3,  32'd0}, // R3 code3
    '{2'd0, 7'h00, 32'd0,   4'hF, 8'd3,  32'd0}, // all strobes
    '{2'd2, 7'h04, 32'd0,   4'h0, 8'd3,  32'd3}, // R3 no count
    '{2'd2, 7'h08, 32'd0,   4'h0, 8'd3,  32'd3}, // R3 ctrl readback
    '{2'd1, 7'h01, 32'd9,   4'h0, 8'd1,  32'd0}, // R1 misaligned write
    '{2'd2, 7'h00, 32'd0,   4'h0, 8'd1,  32'd3}, // R1 unchanged
    '{2'd2, 7'h02, 32'd0,   4'h0, 8'd1,  32'd0}, // R1 misaligned read
    '{2'd1, 7'h00, 32'd7,   4'h0, 8'd2,  32'd0}, // R2 limit only
    '{2'd2, 7'h04, 32'd0,   4'h0, 8'd2,  32'd3}  // R2 count kept
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tick_en = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // drive one cycle at a negedge, return to idle at the next negedge
  task automatic cyc(input logic [1:0] k, input logic [6:0] a,
                     input logic [31:0] d, input logic [3:0] t);
    @(negedge clk);
    bus_valid = (k != 2'd0);
    bus_write = (k == 2'd1);
    bus_addr  = a;
    bus_wdata = d;
    tick_en   = t;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; tick_en = '0;
  endtask

  task automatic rd(input string tag, input logic [6:0] a, input logic [31:0] exp);
    cyc(2'd2, a, 32'd0, 4'h0);
    check(tag, rsp_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 irq in reset", 32'(irq), 32'd0);
    rst_n = 1'b1;

    // R10: reset state
    rd("R10 limit0", 7'h00, 32'd0);
    rd("R10 count0", 7'h04, 32'd0);
    rd("R10 mstat", 7'h54, 32'd0);
    check("R11 ready", 32'(bus_ready), 32'd1);

    for (int i = 0; i < NV; i++) begin
      cyc(VECS[i].k, VECS[i].a, VECS[i].d, VECS[i].t);
      if (VECS[i].k == 2'd2) begin
        n_chk++;
        if (rsp_rdata !== VECS[i].e || rsp_valid !== 1'b1) begin
          n_bad++;
          $display("FAIL R%0d vector %0d: got %0h expected %0h", VECS[i].req, i, rsp_rdata, VECS[i].e);
        end
      end
    end

    // R11: response only after a read
    @(negedge clk);
    check("R11 idle rsp", 32'(rsp_valid), 32'd0);
    cyc(2'd1, 7'h5C, 32'd5, 4'h0);
    check("R11 no rsp on write", 32'(rsp_valid), 32'd0);
    rd("R1 out of window", 7'h5C, 32'd0);

    // R8: expiry and acknowledge in the same cycle, set wins
    cyc(2'd1, 7'h00, 32'd1, 4'h0);
    cyc(2'd1, 7'h48, 32'd1, 4'h0);
    cyc(2'd1, 7'h08, 32'hC, 4'h0);
    check("R9 irq low before expiry", 32'(irq), 32'd0);
    cyc(2'd1, 7'h4C, 32'd1, 4'h1);
    check("R8 set wins irq", 32'(irq), 32'd1);
    rd("R8 mstat after race", 7'h54, 32'd1);
    cyc(2'd1, 7'h4C, 32'd1, 4'h0);
    check("R9 irq low after ack", 32'(irq), 32'd0);

    // R10: reset in the middle of operation
    cyc(2'd0, 7'h00, 32'd0, 4'h1);
    check("R9 irq raised again", 32'(irq), 32'd1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R10 irq during reset", 32'(irq), 32'd0);
    rst_n = 1'b1;
    rd("R10 limit0 cleared", 7'h00, 32'd0);
    rd("R10 ctrl0 cleared", 7'h08, 32'd0);
    rd("R10 mask cleared", 7'h48, 32'd0);
    rd("R10 count1 cleared", 7'h14, 32'd0);
    cyc(2'd0, 7'h00, 32'd0, 4'hF);
    rd("R10 timers stopped", 7'h04, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule